// File: doc/BRIEF.md
# Receive Error Tally Counters

This block keeps three small statistics counters beside a network receiver. One counts frames that arrived with an alignment error, one counts frames that failed the CRC check, and one counts frames that were lost. The receive logic reports each finished frame with a one-cycle end-of-frame strobe. The strobe carries flags for address acceptance, alignment error, CRC error and buffer exhaustion. The block turns these flags into increments. Only frames that passed address recognition are counted.

A host reads a counter by raising a read enable and choosing the counter with a 2-bit select. The value appears on the read port in the same cycle. At the next clock edge the counter that was read returns to zero. Each counter stops at 192 and stays there until it is read. A monitor input changes what the lost-frames counter counts. In monitor mode it counts every accepted frame, so software can measure the traffic that passes the address filter.

Top module: `rx_err_tally`

## Requirements
- R1: After the asynchronous reset is released, all three counters read as zero.
- R2: The alignment counter (select 0) gains exactly one per clock in which `frame_end`, `addr_hit` and `err_align` are all high.
- R3: The CRC counter (select 1) gains exactly one per clock in which `frame_end`, `addr_hit` and `err_crc` are all high.
- R4: A strobe with `addr_hit` low changes no counter, whatever its flags are. Flags given without `frame_end` also change no counter.
- R5: When `monitor` is low, the lost-frames counter (select 2) gains one per accepted strobe that has `buf_full` high.
- R6: When `monitor` is high, the lost-frames counter gains one per accepted strobe, whether `buf_full` is high or low.
- R7: No counter goes above 192. Further qualifying events leave it at 192.
- R8: While `rd_en` is high, `rd_data` shows the selected counter in the same cycle, and that counter is zero after the next edge. The other counters are unaffected. Select 3 returns 0 and clears nothing.
- R9: If an increment and a read of the same counter happen in the same cycle, the read shows the old value and the counter ends at 1.
- R10: `rd_data` is 0 whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_end | input | 1 | One-cycle strobe at the end of each received frame |
| addr_hit | input | 1 | Frame passed address recognition |
| err_align | input | 1 | Frame had an alignment error |
| err_crc | input | 1 | Frame failed the CRC check |
| buf_full | input | 1 | Frame could not be stored because no buffer space was available |
| monitor | input | 1 | Monitor mode: the lost counter counts all accepted frames |
| rd_en | input | 1 | Host read strobe; clears the selected counter |
| rd_sel | input | 2 | Counter select: 0 alignment, 1 CRC, 2 lost, 3 none |
| rd_data | output | 8 | Value of the selected counter |

## Verification
A counter with a wrong value shows up the next time the host reads it. The read path is combinational, so the wrong value is on `rd_data` in the same cycle. A clear that did not happen shows up on a second read one cycle later. An increment applied to the wrong counter, or an increment that should have been blocked, shows up when all three counters are read back after a pattern. A ceiling that is wrong shows up only after at least 193 qualifying events, so the bench drives the counter past the ceiling before it reads.

// File: rtl/tally_pkg.sv
package tally_pkg;
  localparam int CNT_W   = 8;
  localparam int CNT_MAX = 192;
  localparam int NUM_CNT = 3;
  localparam int SEL_W   = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_ALIGN = 2'd0,
    SEL_CRC   = 2'd1,
    SEL_LOST  = 2'd2,
    SEL_NONE  = 2'd3
  } tally_sel_e;
endpackage

// File: rtl/tally_rst_sync.sv
module tally_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/tally_qualify.sv
module tally_qualify
  import tally_pkg::*;
#(
  parameter int NUM = NUM_CNT
) (
  input  logic           frame_end,
  input  logic           addr_hit,
  input  logic           err_align,
  input  logic           err_crc,
  input  logic           buf_full,
  input  logic           monitor,
  output logic [NUM-1:0] inc
);
  logic accepted;

  always_comb begin
    accepted = frame_end & addr_hit;
    inc      = '0;
    inc[SEL_ALIGN] = accepted & err_align;
    inc[SEL_CRC]   = accepted & err_crc;
    inc[SEL_LOST]  = accepted & (monitor | buf_full);
  end
endmodule

// File: rtl/tally_counter.sv
module tally_counter #(
  parameter int W   = 8,
  parameter int MAX = 192
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX_V = W'(MAX);
  localparam logic [W-1:0] ONE_V = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clr_i) begin
      cnt_en = 1'b1;
      cnt_d  = inc_i ? ONE_V : '0;
    end else if (inc_i && (cnt_q != MAX_V)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + ONE_V;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tally_rdmux.sv
module tally_rdmux #(
  parameter int W     = 8,
  parameter int NUM   = 3,
  parameter int SEL_W = 2
) (
  input  logic                rd_en,
  input  logic [SEL_W-1:0]    rd_sel,
  input  logic [NUM-1:0][W-1:0] cnt,
  output logic [W-1:0]        rd_data,
  output logic [NUM-1:0]      clr
);
  always_comb begin
    rd_data = '0;
    clr     = '0;
    if (rd_en) begin
      for (int i = 0; i < NUM; i++) begin
        if (rd_sel == SEL_W'(i)) begin
          rd_data = cnt[i];
          clr[i]  = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rx_err_tally.sv
module rx_err_tally
  import tally_pkg::*;
#(
  parameter int W   = CNT_W,
  parameter int MAX = CNT_MAX
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_end,
  input  logic             addr_hit,
  input  logic             err_align,
  input  logic             err_crc,
  input  logic             buf_full,
  input  logic             monitor,
  input  logic             rd_en,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [W-1:0]     rd_data
);
  localparam int NUM = NUM_CNT;

  logic                 rst_sync_n;
  logic [NUM-1:0]       inc_vec;
  logic [NUM-1:0]       clr_vec;
  logic [NUM-1:0][W-1:0] cnt_all;

  tally_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tally_qualify #(.NUM(NUM)) u_qual (
    .frame_end (frame_end),
    .addr_hit  (addr_hit),
    .err_align (err_align),
    .err_crc   (err_crc),
    .buf_full  (buf_full),
    .monitor   (monitor),
    .inc       (inc_vec)
  );

  for (genvar g = 0; g < NUM; g++) begin : g_cnt
    tally_counter #(.W(W), .MAX(MAX)) u_cnt (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .inc_i (inc_vec[g]),
      .clr_i (clr_vec[g]),
      .cnt_o (cnt_all[g])
    );
  end

  tally_rdmux #(.W(W), .NUM(NUM), .SEL_W(SEL_W)) u_mux (
    .rd_en   (rd_en),
    .rd_sel  (rd_sel),
    .cnt     (cnt_all),
    .rd_data (rd_data),
    .clr     (clr_vec)
  );
endmodule

// File: rtl/tally_chk.sv
module tally_chk #(
  parameter int W   = 8,
  parameter int MAX = 192,
  parameter int NUM = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM-1:0]        inc,
  input logic [NUM-1:0]        clr,
  input logic [NUM-1:0][W-1:0] cnt,
  input logic                  rd_en,
  input logic [W-1:0]          rd_data
);
  localparam logic [W-1:0] MAX_V = W'(MAX);

  for (genvar g = 0; g < NUM; g++) begin : g_p
    // R7: ceiling never exceeded
    p_ceiling_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[g] <= MAX_V);
    // R7: a saturated counter holds under further events
    p_sat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (inc[g] && !clr[g] && cnt[g] == MAX_V) |=> cnt[g] == MAX_V);
    // R2, R3, R5: one increment per qualifying pulse
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (inc[g] && !clr[g] && cnt[g] != MAX_V) |=> cnt[g] == $past(cnt[g]) + W'(1));
    // R4: no event, no read, no change
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc[g] && !clr[g]) |=> $stable(cnt[g]));
    // R8: a plain read clears
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[g] && !inc[g]) |=> cnt[g] == '0);
    // R9: read colliding with an increment leaves one
    p_collide_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[g] && inc[g]) |=> cnt[g] == W'(1));
  end

  // R8: at most one counter cleared per read
  p_one_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr));
  // R10: idle read port is zero
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rd_data == '0);
endmodule

bind rx_err_tally tally_chk #(.W(W), .MAX(MAX), .NUM(NUM)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .inc     (inc_vec),
  .clr     (clr_vec),
  .cnt     (cnt_all),
  .rd_en   (rd_en),
  .rd_data (rd_data)
);

// File: tb/sim_rx_err_tally.sv
`timescale 1ns/1ps
module sim_rx_err_tally;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       frame_end, addr_hit, err_align, err_crc, buf_full, monitor, rd_en;
  logic [1:0] rd_sel;
  logic [7:0] rd_data;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rx_err_tally u0 (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .addr_hit(addr_hit),
    .err_align(err_align), .err_crc(err_crc), .buf_full(buf_full),
    .monitor(monitor), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  // {frame_end, addr_hit, err_align, err_crc, buf_full, monitor, rd_en, rd_sel[1:0], expected[7:0]}
  localparam int NV = 18;
  localparam logic [16:0] VEC [NV] = '{
    {9'b000000_1_00, 8'd0},  // R1 align zero
    {9'b000000_1_01, 8'd0},  // R1 crc zero
    {9'b000000_1_10, 8'd0},  // R1 lost zero
    {9'b111000_0_00, 8'd0},  // R2 align event
    {9'b111100_0_00, 8'd0},  // R2 R3 both flags
    {9'b101110_0_00, 8'd0},  // R4 not accepted
    {9'b110010_0_00, 8'd0},  // R5 no buffer
    {9'b110001_0_00, 8'd0},  // R6 monitor counts
    {9'b011110_0_00, 8'd0},  // R4 no strobe
    {9'b000000_1_00, 8'd2},  // R2 read align
    {9'b000000_1_00, 8'd0},  // R8 cleared
    {9'b000000_1_01, 8'd1},  // R3 read crc
    {9'b000000_1_11, 8'd0},  // R8 select 3
    {9'b000000_1_10, 8'd2},  // R5 R6 read lost
    {9'b111000_1_00, 8'd0},  // R9 collide align
    {9'b000000_1_00, 8'd1},  // R9 ends at one
    {9'b110010_1_10, 8'd0},  // R9 collide lost
    {9'b000000_1_10, 8'd1}   // R9 ends at one
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [8:0] c);
    @(negedge clk);
    {frame_end, addr_hit, err_align, err_crc, buf_full, monitor, rd_en, rd_sel} = c;
    #2;
  endtask

  task automatic idle();
    drive(9'b0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    {frame_end, addr_hit, err_align, err_crc, buf_full, monitor, rd_en, rd_sel} = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][16:8]);
      chk($sformatf("vector %0d", i), rd_data, VEC[i][7:0]);
    end
    idle();
    chk("R10 idle port", rd_data, 8'd0);

    // R7 saturation on the alignment counter
    for (int k = 0; k < 200; k++) drive(9'b111000_0_00);
    drive(9'b000000_1_01);
    chk("R7 crc untouched", rd_data, 8'd0);
    drive(9'b000000_1_00);
    chk("R7 align at ceiling", rd_data, 8'd192);
    drive(9'b000000_1_00);
    chk("R8 cleared after saturation", rd_data, 8'd0);

    // R7 on lost counter in monitor mode, exactly at and past 192
    for (int k = 0; k < 192; k++) drive(9'b110001_0_00);
    drive(9'b110001_1_10);
    chk("R9 R7 collide at ceiling", rd_data, 8'd192);
    drive(9'b000000_1_10);
    chk("R9 collide leaves one", rd_data, 8'd1);

    // R1 reset in the middle of activity
    for (int k = 0; k < 3; k++) drive(9'b110100_0_00);
    idle();
    rst_n = 1'b0;
    #2 rst_n = 1'b1;
    repeat (4) idle();
    drive(9'b000000_1_01);
    chk("R1 crc after reset", rd_data, 8'd0);
    idle();

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      summary();
      $finish;
    end
  end
endmodule